// File: doc/BRIEF.md
# Byte-Lane RAM with Held Address and Split Mode

This block is a single-clock synchronous RAM of 256 words by 16 bits. Each word is split into two 8-bit byte lanes, and each lane has its own write-enable bit, so a write can change only the upper byte, only the lower byte, or both. The address goes through a register. A per-port address enable decides each cycle whether that register takes the new address or keeps the one it holds, so a caller can keep working on one word without driving its address again.

A static mode input splits the array into two independent single-port memories of 128 words each, both on the same clock. Port A owns the lower half and port B owns the upper half. Port B has its own address, write data, lane enables, write enable and address enable. When split mode is off, port A addresses all 256 words and port B cannot write. Reads are synchronous. The output register shows the word one clock edge after its address is taken. In a write cycle, the output shows the new data on the enabled lanes and an undefined value on the other lanes.

Top module: `byte_lane_ram`

## Requirements
- R1: A write with lane enables 2'b11 (bit 1 = upper byte [15:8], bit 0 = lower byte [7:0]) stores the whole 16-bit word, and a later read returns it.
- R2: A write with lane enables 2'b10 changes only bits [15:8]. A word holding 16'hFFFF written with 16'hABCD reads back as 16'hABFF.
- R3: A write with lane enables 2'b01 changes only bits [7:0]. A word holding 16'hFFFF written with 16'hABCD reads back as 16'hFFCD.
- R4: On the clock edge of a write, the port output takes the written data on every enabled lane. Lanes that are not enabled are undefined in that cycle.
- R5: When write enable is low, the output after each edge equals the stored word at the effective address, and memory contents do not change.
- R6: When a port's address enable is high, its address register captures the address input at the edge. When it is low, the register keeps its value, and both the read and any write in that cycle use the held address.
- R7: While reset is active, and until the first edge after reset is released, both outputs read 0 and both address registers read 0. Reset asserts asynchronously and releases on the second clock edge after the reset pin goes high.
- R8: With split mode high, port A uses physical word {0, A address[6:0]} and ignores A address bit 7, and port B uses physical word {1, B address[6:0]}. The two halves stay independent. The held port A address keeps all 8 bits.
- R9: In split mode, each port's address enable acts only on that port's own address register.
- R10: With split mode low, a port B write changes no stored word.
- R11: A write with lane enables 2'b00 changes no stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| split_mode | input | 1 | 1 = two independent 128-word memories |
| a_we | input | 1 | Port A write enable |
| a_be | input | 2 | Port A lane enables, bit 1 = upper byte |
| a_addr | input | 8 | Port A address |
| a_wdata | input | 16 | Port A write data |
| a_ace | input | 1 | Port A address register enable |
| a_q | output | 16 | Port A registered read data |
| b_we | input | 1 | Port B write enable (split mode only) |
| b_be | input | 2 | Port B lane enables, bit 1 = upper byte |
| b_addr | input | 7 | Port B address within the upper half |
| b_wdata | input | 16 | Port B write data |
| b_ace | input | 1 | Port B address register enable |
| b_q | output | 16 | Port B registered read data |

## Verification
A stale or wrongly captured address register shows up at the next edge: the read word comes from the wrong address, or a write with the enable low lands somewhere other than the held word. A lane-mask fault shows up on the first read-back, as a neighbouring byte that was overwritten or left unchanged. A wrong half selection in split mode shows up the next time the other port reads the aliased word, or when the array is read in whole mode after split mode is switched off. Each of these faults appears on an output within one or two clocks of the access that causes it.

// File: rtl/blr_pkg.sv
package blr_pkg;
  localparam int unsigned LANE_W = 8;
  typedef enum logic { HALF_LOW = 1'b0, HALF_HIGH = 1'b1 } half_sel_e;
endpackage

// File: rtl/blr_addr_hold.sv
module blr_addr_hold #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ace,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_eff,
  output logic [AW-1:0] addr_held
);
  // The effective address is the one used at this edge; the register keeps it.
  always_comb begin
    addr_eff = ace ? addr_in : addr_held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_held <= '0;
    else        addr_held <= addr_eff;
  end
endmodule

// File: rtl/blr_array.sv
module blr_array #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned LANES = DW / blr_pkg::LANE_W,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_a,
  input  logic [LANES-1:0] be_a,
  input  logic [AW-1:0]    addr_a,
  input  logic [DW-1:0]    wdata_a,
  input  logic             wr_b,
  input  logic [LANES-1:0] be_b,
  input  logic [AW-1:0]    addr_b,
  input  logic [DW-1:0]    wdata_b,
  output logic [DW-1:0]    rdata_a,
  output logic [DW-1:0]    rdata_b
);
  localparam int unsigned LW = blr_pkg::LANE_W;

  logic [DW-1:0] mem [DEPTH];

  always_comb begin
    rdata_a = mem[addr_a];
    rdata_b = mem[addr_b];
  end

  // Storage has no reset; each lane is written only when its enable is set.
  always_ff @(posedge clk) begin
    for (int l = 0; l < int'(LANES); l++) begin
      if (wr_a && be_a[l]) mem[addr_a][l*LW +: LW] <= wdata_a[l*LW +: LW];
      if (wr_b && be_b[l]) mem[addr_b][l*LW +: LW] <= wdata_b[l*LW +: LW];
    end
  end
endmodule

// File: rtl/blr_read_reg.sv
module blr_read_reg #(
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = DW / blr_pkg::LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    rdata,
  output logic [DW-1:0]    q
);
  localparam int unsigned LW = blr_pkg::LANE_W;

  logic [DW-1:0] q_nxt;

  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    always_comb begin
      if (wr && be[l])  q_nxt[l*LW +: LW] = wdata[l*LW +: LW];
      else if (wr)      q_nxt[l*LW +: LW] = {LW{1'bx}};
      else              q_nxt[l*LW +: LW] = rdata[l*LW +: LW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/byte_lane_ram.sv
module byte_lane_ram #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANES  = DATA_W / blr_pkg::LANE_W,
  parameter int unsigned ADDR_W = $clog2(DEPTH),
  parameter int unsigned HALF_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_mode,
  input  logic              a_we,
  input  logic [LANES-1:0]  a_be,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_ace,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_we,
  input  logic [LANES-1:0]  b_be,
  input  logic [HALF_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_ace,
  output logic [DATA_W-1:0] b_q
);
  import blr_pkg::*;

  // Reset: asynchronous assert, release after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [ADDR_W-1:0] a_eff, a_held;
  logic [HALF_W-1:0] b_eff, b_held;

  blr_addr_hold #(.AW(ADDR_W)) u_hold_a (
    .clk(clk), .rst_n(rst_sync_n), .ace(a_ace), .addr_in(a_addr),
    .addr_eff(a_eff), .addr_held(a_held)
  );

  blr_addr_hold #(.AW(HALF_W)) u_hold_b (
    .clk(clk), .rst_n(rst_sync_n), .ace(b_ace), .addr_in(b_addr),
    .addr_eff(b_eff), .addr_held(b_held)
  );

  // Physical addresses: in split mode the top bit selects the half.
  logic [ADDR_W-1:0] a_phys, b_phys;
  logic              a_wr, b_wr;
  always_comb begin
    a_phys = split_mode ? {HALF_LOW, a_eff[HALF_W-1:0]} : a_eff;
    b_phys = {HALF_HIGH, b_eff};
    a_wr   = a_we && rst_sync_n;
    b_wr   = b_we && split_mode && rst_sync_n;
  end

  logic [DATA_W-1:0] a_rd, b_rd;

  blr_array #(.DW(DATA_W), .DEPTH(DEPTH), .LANES(LANES), .AW(ADDR_W)) u_array (
    .clk(clk),
    .wr_a(a_wr), .be_a(a_be), .addr_a(a_phys), .wdata_a(a_wdata),
    .wr_b(b_wr), .be_b(b_be), .addr_b(b_phys), .wdata_b(b_wdata),
    .rdata_a(a_rd), .rdata_b(b_rd)
  );

  blr_read_reg #(.DW(DATA_W), .LANES(LANES)) u_rd_a (
    .clk(clk), .rst_n(rst_sync_n), .wr(a_we), .be(a_be),
    .wdata(a_wdata), .rdata(a_rd), .q(a_q)
  );

  blr_read_reg #(.DW(DATA_W), .LANES(LANES)) u_rd_b (
    .clk(clk), .rst_n(rst_sync_n), .wr(b_we && split_mode), .be(b_be),
    .wdata(b_wdata), .rdata(b_rd), .q(b_q)
  );
endmodule

// File: rtl/blr_checker.sv
module blr_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned HALF_W = 7
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              split_mode,
  input logic              a_we,
  input logic [LANES-1:0]  a_be,
  input logic [ADDR_W-1:0] a_addr,
  input logic [DATA_W-1:0] a_wdata,
  input logic              a_ace,
  input logic [ADDR_W-1:0] a_held,
  input logic [DATA_W-1:0] a_q,
  input logic              b_we,
  input logic [LANES-1:0]  b_be,
  input logic [HALF_W-1:0] b_addr,
  input logic [DATA_W-1:0] b_wdata,
  input logic              b_ace,
  input logic [HALF_W-1:0] b_held,
  input logic [DATA_W-1:0] b_q,
  input logic              b_wr
);
  localparam int unsigned LW = blr_pkg::LANE_W;

  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    a_r4_a_lane_written: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (a_we && a_be[l]) |=> (a_q[l*LW +: LW] == $past(a_wdata[l*LW +: LW])));
    a_r4_b_lane_written: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (split_mode && b_we && b_be[l]) |=> (b_q[l*LW +: LW] == $past(b_wdata[l*LW +: LW])));
  end

  a_r6_a_capture: assert property (@(posedge clk) disable iff (!rst_sync_n)
    a_ace |=> (a_held == $past(a_addr)));
  a_r6_a_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !a_ace |=> $stable(a_held));
  a_r9_b_capture: assert property (@(posedge clk) disable iff (!rst_sync_n)
    b_ace |=> (b_held == $past(b_addr)));
  a_r9_b_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !b_ace |=> $stable(b_held));
  a_r10_b_write_blocked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !split_mode |-> !b_wr);
endmodule

bind byte_lane_ram blr_checker #(
  .DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W), .HALF_W(HALF_W)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .split_mode(split_mode),
  .a_we(a_we), .a_be(a_be), .a_addr(a_addr), .a_wdata(a_wdata), .a_ace(a_ace),
  .a_held(a_held), .a_q(a_q),
  .b_we(b_we), .b_be(b_be), .b_addr(b_addr), .b_wdata(b_wdata), .b_ace(b_ace),
  .b_held(b_held), .b_q(b_q), .b_wr(b_wr)
);

// File: tb/byte_lane_ram_tb.sv
module byte_lane_ram_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        split_mode;
  logic        a_we, a_ace, b_we, b_ace;
  logic [1:0]  a_be, b_be;
  logic [7:0]  a_addr;
  logic [6:0]  b_addr;
  logic [15:0] a_wdata, b_wdata;
  logic [15:0] a_q, b_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_lane_ram u_dut (
    .clk(clk), .rst_n(rst_n), .split_mode(split_mode),
    .a_we(a_we), .a_be(a_be), .a_addr(a_addr), .a_wdata(a_wdata), .a_ace(a_ace), .a_q(a_q),
    .b_we(b_we), .b_be(b_be), .b_addr(b_addr), .b_wdata(b_wdata), .b_ace(b_ace), .b_q(b_q)
  );

  typedef struct {
    bit          port_b;
    logic [15:0] mask;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  logic [15:0] ref_mem [256];
  logic [7:0]  held_a;
  logic [6:0]  held_b;

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp,
                       input logic [15:0] mask);
    n_run++;
    if ((act & mask) !== (exp & mask)) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (mask %h)", tag, act, exp, mask);
    end
  endtask

  // One clock of stimulus on both ports; the expected outputs go to the scoreboard.
  task automatic step(input bit awe, input logic [1:0] abe, input logic [7:0] aaddr,
                      input logic [15:0] awd, input bit aace,
                      input bit bwe, input logic [1:0] bbe, input logic [6:0] baddr,
                      input logic [15:0] bwd, input bit bace,
                      input bit sm, input string ta, input string tb, input bit chk_b);
    logic [7:0] ea, pa, pb;
    logic [6:0] eb;
    item_t ia, ib;
    @(negedge clk);
    a_we = awe; a_be = abe; a_addr = aaddr; a_wdata = awd; a_ace = aace;
    b_we = bwe; b_be = bbe; b_addr = baddr; b_wdata = bwd; b_ace = bace;
    split_mode = sm;
    ea = aace ? aaddr : held_a;
    eb = bace ? baddr : held_b;
    pa = sm ? {1'b0, ea[6:0]} : ea;
    pb = {1'b1, eb};
    ia.port_b = 1'b0; ia.tag = ta;
    ia.mask = awe ? lane_mask(abe) : 16'hFFFF;
    ia.exp  = awe ? awd : ref_mem[pa];
    ib.port_b = 1'b1; ib.tag = tb;
    ib.mask = (sm && bwe) ? lane_mask(bbe) : 16'hFFFF;
    ib.exp  = (sm && bwe) ? bwd : ref_mem[pb];
    if (awe) ref_mem[pa] = (ref_mem[pa] & ~lane_mask(abe)) | (awd & lane_mask(abe));
    if (sm && bwe) ref_mem[pb] = (ref_mem[pb] & ~lane_mask(bbe)) | (bwd & lane_mask(bbe));
    held_a = ea;
    held_b = eb;
    @(posedge clk);
    #1;
    sbq.push_back(ia);
    if (chk_b) sbq.push_back(ib);
  endtask

  task automatic wr_a(input logic [7:0] ad, input logic [15:0] d, input logic [1:0] be,
                      input bit sm, input string tag);
    step(1'b1, be, ad, d, 1'b1, 1'b0, 2'b00, 7'd0, 16'h0, 1'b0, sm, tag, "", 1'b0);
  endtask

  task automatic rd_a(input logic [7:0] ad, input bit sm, input string tag);
    step(1'b0, 2'b00, ad, 16'h0, 1'b1, 1'b0, 2'b00, 7'd0, 16'h0, 1'b0, sm, tag, "", 1'b0);
  endtask

  // Monitor: compares every queued expectation against the outputs.
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(it.tag, it.port_b ? b_q : a_q, it.exp, it.mask);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; split_mode = 1'b0;
    a_we = 1'b0; a_be = 2'b00; a_addr = 8'd0; a_wdata = 16'h0; a_ace = 1'b0;
    b_we = 1'b0; b_be = 2'b00; b_addr = 7'd0; b_wdata = 16'h0; b_ace = 1'b0;
    held_a = 8'd0; held_b = 7'd0;
    for (int i = 0; i < 256; i++) ref_mem[i] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 a_q in reset", a_q, 16'h0, 16'hFFFF);
    check("R7 b_q in reset", b_q, 16'h0, 16'hFFFF);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R7 a_q after release", a_q, 16'h0, 16'hFFFF);
    check("R7 b_q after release", b_q, 16'h0, 16'hFFFF);

    // R1/R2/R3/R4: lane-masked writes
    wr_a(8'h00, 16'hFFFF, 2'b11, 1'b0, "R1 fill");
    wr_a(8'h01, 16'hFFFF, 2'b11, 1'b0, "R1 fill");
    wr_a(8'h02, 16'hFFFF, 2'b11, 1'b0, "R1 fill");
    wr_a(8'h00, 16'hABCD, 2'b10, 1'b0, "R4 upper lane");
    wr_a(8'h01, 16'hABCD, 2'b01, 1'b0, "R4 lower lane");
    wr_a(8'h02, 16'hABCD, 2'b11, 1'b0, "R4 full word");
    rd_a(8'h00, 1'b0, "R2 upper only");
    rd_a(8'h01, 1'b0, "R3 lower only");
    rd_a(8'h02, 1'b0, "R1 full word");
    // R11: write with no lanes enabled
    wr_a(8'h02, 16'h1234, 2'b00, 1'b0, "R11 no lanes");
    rd_a(8'h02, 1'b0, "R11 unchanged");
    // R5: repeated reads, nothing written
    rd_a(8'h01, 1'b0, "R5 read");
    rd_a(8'h01, 1'b0, "R5 read again");
    // R6: address hold for read and write
    rd_a(8'h00, 1'b0, "R6 capture");
    step(1'b0, 2'b00, 8'h01, 16'h0, 1'b0, 1'b0, 2'b00, 7'd0, 16'h0, 1'b0, 1'b0,
         "R6 held read", "", 1'b0);
    step(1'b1, 2'b11, 8'h40, 16'h7777, 1'b0, 1'b0, 2'b00, 7'd0, 16'h0, 1'b0, 1'b0,
         "R6 held write", "", 1'b0);
    rd_a(8'h00, 1'b0, "R6 write went to held");
    rd_a(8'h01, 1'b0, "R6 other word intact");
    // R10: port B write blocked in whole mode
    wr_a(8'h85, 16'h1111, 2'b11, 1'b0, "R10 seed");
    step(1'b0, 2'b00, 8'h00, 16'h0, 1'b0, 1'b1, 2'b11, 7'h05, 16'h5555, 1'b1, 1'b0,
         "R10 during B write", "", 1'b0);
    rd_a(8'h85, 1'b0, "R10 word unchanged");
    // R8: split mode halves
    wr_a(8'h85, 16'h2222, 2'b11, 1'b1, "R8 A write low half");
    step(1'b0, 2'b00, 8'h05, 16'h0, 1'b0, 1'b1, 2'b11, 7'h05, 16'h3333, 1'b1, 1'b1,
         "R8 A idle", "R4 B write", 1'b1);
    step(1'b0, 2'b00, 8'h05, 16'h0, 1'b1, 1'b0, 2'b00, 7'h05, 16'h0, 1'b1, 1'b1,
         "R8 A low half", "R8 B high half", 1'b1);
    rd_a(8'h85, 1'b1, "R8 top bit ignored");
    // R9: independent address enables, B lane write
    step(1'b0, 2'b00, 8'h00, 16'h0, 1'b0, 1'b1, 2'b11, 7'h06, 16'h4444, 1'b1, 1'b1,
         "R9 A held", "R4 B full", 1'b1);
    step(1'b0, 2'b00, 8'h11, 16'h0, 1'b0, 1'b0, 2'b00, 7'h06, 16'h0, 1'b1, 1'b1,
         "R9 A held while B moves", "R9 B read", 1'b1);
    step(1'b0, 2'b00, 8'h05, 16'h0, 1'b1, 1'b1, 2'b10, 7'h05, 16'h9900, 1'b0, 1'b1,
         "R9 A moves", "R4 B upper held", 1'b1);
    step(1'b0, 2'b00, 8'h05, 16'h0, 1'b0, 1'b0, 2'b00, 7'h05, 16'h0, 1'b1, 1'b1,
         "R9 A held", "R2 B upper only", 1'b1);
    // back to whole mode: B's half seen by A
    rd_a(8'h85, 1'b0, "R8 high half whole");
    rd_a(8'h05, 1'b0, "R8 low half whole");
    rd_a(8'h86, 1'b0, "R8 high half whole");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule